// File: doc/BRIEF.md
# Three-Slot Receive Message Queue

This block sits between an acceptance filter and a host bus on the receive side of a CAN controller. Each message that passes the filter arrives on a single-cycle write strobe as four 32-bit words: an identifier word, a length word (data length code in bits 3:0, accepting filter index in bits 15:8, timestamp in the upper half), a low data word and a high data word. The queue keeps up to three such messages and always presents the oldest one on its output mailbox. The host reads the mailbox and then pulses the release input to drop it, which brings the next oldest message forward.

Occupancy is held by a four-state machine: `OCC_EMPTY`, `OCC_ONE`, `OCC_TWO` and `OCC_FULL`, whose encoding is the pending count. The transitions are *receive* (a message is stored, moving one state up), *release* (the oldest is dropped, moving one state down), *swap* (receive and release in the same cycle, staying in the same state), *overflow* (a receive in `OCC_FULL` with no release, staying in `OCC_FULL` and raising the overrun flag) and *idle* (nothing, or a release in `OCC_EMPTY`, staying put). A lock-mode input selects the overflow policy: unlocked, the incoming message replaces the most recently stored one; locked, the incoming message is thrown away. The overrun flag stays set until the host pulses the overrun-clear input.

Top module: `msg_rx_queue`

## Requirements
- R1: After reset the pending count is 0 and the full and overrun flags are 0.
- R2: A write strobe with fewer than three messages stored raises the pending count by one on the next clock; the mailbox keeps showing the oldest stored message, so messages leave in arrival order.
- R3: A release pulse with at least one message stored lowers the pending count by one on the next clock and the mailbox then shows the next oldest message.
- R4: A write strobe and a release pulse in the same cycle leave the pending count unchanged; with one message stored, the mailbox then shows the message just written, and with three stored no overrun occurs.
- R5: The full flag is 1 exactly when three messages are stored and goes to 0 on the clock after a release drops the count to two.
- R6: A write strobe with three messages stored and no release sets the overrun flag on the next clock, the pending count stays 3 and the mailbox still shows the oldest message.
- R7: With lock mode 0, the overflowing message replaces the most recently stored message; the two older messages are kept.
- R8: With lock mode 1, the overflowing message is discarded and the three oldest messages are kept in order.
- R9: A pulse on the overrun-clear input clears the overrun flag on the next clock; if an overflow happens in the same cycle the flag stays set.
- R10: A release pulse with the queue empty is ignored: the count stays 0 and the next received message is presented intact.
- R11: The mailbox length word is delivered unchanged, so bits 15:8 show the index of the filter that accepted the presented message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_mode | input | 1 | Overflow policy: 0 replace newest, 1 discard incoming |
| wr_en | input | 1 | Accepted-message write strobe |
| wr_id | input | 32 | Identifier word of incoming message |
| wr_len | input | 32 | Length word (DLC 3:0, filter index 15:8, timestamp 31:16) |
| wr_dlo | input | 32 | Low data word of incoming message |
| wr_dhi | input | 32 | High data word of incoming message |
| rel_req | input | 1 | Release pulse for the output mailbox |
| ovr_clr | input | 1 | Overrun flag clear pulse |
| pend_cnt | output | 2 | Number of stored messages, 0 to 3 |
| full_flag | output | 1 | Three messages stored |
| ovr_flag | output | 1 | A message was lost to overflow |
| mb_id | output | 32 | Identifier word of oldest message |
| mb_len | output | 32 | Length word of oldest message |
| mb_dlo | output | 32 | Low data word of oldest message |
| mb_dhi | output | 32 | High data word of oldest message |

## Verification
The properties assume that the write strobe, release and overrun-clear inputs are single-cycle decisions sampled at the clock and that reset is held low from time zero for at least one edge, so no pending-count history exists before the first checked cycle. They also assume lock mode is only changed while no overflow is in flight, since the overflow properties sample it in the same cycle as the strobe. The stimulus drives every input on the falling edge, holds reset low for several cycles at start and changes lock mode only between table rows where the queue is not overflowing.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned SLOTS  = 3;
    localparam int unsigned CNT_W  = $clog2(SLOTS + 1);
    localparam int unsigned PTR_W  = $clog2(SLOTS);

    typedef struct packed {
        logic [WORD_W-1:0] id;
        logic [WORD_W-1:0] len;
        logic [WORD_W-1:0] dlo;
        logic [WORD_W-1:0] dhi;
    } msg_t;

    typedef enum logic [CNT_W-1:0] {
        OCC_EMPTY = 2'd0,
        OCC_ONE   = 2'd1,
        OCC_TWO   = 2'd2,
        OCC_FULL  = 2'd3
    } occ_e;

endpackage

// File: rtl/rxq_occ_fsm.sv
module rxq_occ_fsm
    import rxq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_acc,
    input  logic rel_req,
    input  logic lock_mode,
    output occ_e state_q,
    output logic push,
    output logic pop,
    output logic overwrite,
    output logic overflow
);

    occ_e state_d;

    // Action decode for the current state.
    always_comb begin
        push      = 1'b0;
        pop       = 1'b0;
        overwrite = 1'b0;
        overflow  = 1'b0;
        unique case (state_q)
            OCC_EMPTY: begin
                push = rx_acc;
            end
            OCC_ONE, OCC_TWO: begin
                push = rx_acc;
                pop  = rel_req;
            end
            OCC_FULL: begin
                pop       = rel_req;
                push      = rx_acc && (rel_req || !lock_mode);
                overwrite = rx_acc && !rel_req && !lock_mode;
                overflow  = rx_acc && !rel_req;
            end
            default: begin
                push = 1'b0;
            end
        endcase
    end

    // Next-state selection from the decoded actions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OCC_EMPTY: if (push)               state_d = OCC_ONE;
            OCC_ONE:   if (push && !pop)       state_d = OCC_TWO;
                       else if (pop && !push)  state_d = OCC_EMPTY;
            OCC_TWO:   if (push && !pop)       state_d = OCC_FULL;
                       else if (pop && !push)  state_d = OCC_ONE;
            OCC_FULL:  if (pop && !push)       state_d = OCC_TWO;
            default:                           state_d = OCC_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OCC_EMPTY;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/rxq_slot_store.sv
module rxq_slot_store
    import rxq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             overwrite,
    input  logic [CNT_W-1:0] count,
    input  msg_t             wr_msg,
    output msg_t             head_msg
);

    msg_t             slots [SLOTS];
    logic [PTR_W-1:0] head_q;
    logic [PTR_W-1:0] wr_idx;
    logic [CNT_W-1:0] wr_off;
    logic [SLOTS-1:0] slot_we;

    function automatic logic [PTR_W-1:0] ring_add(logic [PTR_W-1:0] base,
                                                  logic [CNT_W-1:0] off);
        int unsigned sum;
        sum = int'(base) + int'(off);
        if (sum >= SLOTS) sum = sum - SLOTS;
        return PTR_W'(sum);
    endfunction

    // Overwrite targets the newest slot; a plain push targets the tail.
    assign wr_off = overwrite ? (count - CNT_W'(1)) : count;
    assign wr_idx = ring_add(head_q, wr_off);

    for (genvar g = 0; g < SLOTS; g++) begin : g_we
        assign slot_we[g] = push && (wr_idx == PTR_W'(g));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) slots[i] <= '0;
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (slot_we[i]) slots[i] <= wr_msg;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   head_q <= '0;
        else if (pop) head_q <= ring_add(head_q, CNT_W'(1));
    end

    assign head_msg = slots[head_q];

endmodule

// File: rtl/rxq_ovr_flag.sv
module rxq_ovr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_req,
    output logic flag_q
);

    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (set_evt) flag_q <= 1'b1;
        else if (clr_req) flag_q <= 1'b0;
    end

endmodule

// File: rtl/msg_rx_queue.sv
module msg_rx_queue
    import rxq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_mode,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_id,
    input  logic [WORD_W-1:0] wr_len,
    input  logic [WORD_W-1:0] wr_dlo,
    input  logic [WORD_W-1:0] wr_dhi,
    input  logic              rel_req,
    input  logic              ovr_clr,
    output logic [CNT_W-1:0]  pend_cnt,
    output logic              full_flag,
    output logic              ovr_flag,
    output logic [WORD_W-1:0] mb_id,
    output logic [WORD_W-1:0] mb_len,
    output logic [WORD_W-1:0] mb_dlo,
    output logic [WORD_W-1:0] mb_dhi
);

    occ_e state_q;
    logic push, pop, overwrite, overflow;
    msg_t wr_msg, head_msg;

    assign wr_msg = '{id: wr_id, len: wr_len, dlo: wr_dlo, dhi: wr_dhi};

    rxq_occ_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_acc    (wr_en),
        .rel_req   (rel_req),
        .lock_mode (lock_mode),
        .state_q   (state_q),
        .push      (push),
        .pop       (pop),
        .overwrite (overwrite),
        .overflow  (overflow)
    );

    rxq_slot_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .overwrite (overwrite),
        .count     (CNT_W'(state_q)),
        .wr_msg    (wr_msg),
        .head_msg  (head_msg)
    );

    rxq_ovr_flag u_ovr (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (overflow),
        .clr_req (ovr_clr),
        .flag_q  (ovr_flag)
    );

    assign pend_cnt  = CNT_W'(state_q);
    assign full_flag = (state_q == OCC_FULL);
    assign mb_id     = head_msg.id;
    assign mb_len    = head_msg.len;
    assign mb_dlo    = head_msg.dlo;
    assign mb_dhi    = head_msg.dhi;

endmodule

// File: rtl/rxq_check.sv
module rxq_check
    import rxq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              lock_mode,
    input logic              wr_en,
    input logic              rel_req,
    input logic              ovr_clr,
    input logic [CNT_W-1:0]  pend_cnt,
    input logic              full_flag,
    input logic              ovr_flag,
    input logic [WORD_W-1:0] mb_id,
    input logic [WORD_W-1:0] mb_len
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SLOTS);

    assert_count_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rel_req && pend_cnt != CNT_MAX) |=> pend_cnt == $past(pend_cnt) + 2'd1);

    assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_req && !wr_en && pend_cnt != '0) |=> pend_cnt == $past(pend_cnt) - 2'd1);

    assert_swap_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_req && wr_en && pend_cnt != '0) |=> $stable(pend_cnt));

    assert_full_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_flag) |-> $past(pend_cnt) == CNT_MAX - 2'd1);

    assert_overrun_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rel_req && pend_cnt == CNT_MAX) |=> ovr_flag && pend_cnt == CNT_MAX);

    assert_head_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rel_req && !lock_mode && pend_cnt == CNT_MAX) |=> $stable(mb_id) && $stable(mb_len));

    assert_drop_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rel_req && lock_mode && pend_cnt == CNT_MAX) |=> $stable(mb_id) && $stable(mb_len));

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_clr && !(wr_en && !rel_req && pend_cnt == CNT_MAX)) |=> !ovr_flag);

    assert_empty_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_req && !wr_en && pend_cnt == '0) |=> pend_cnt == '0);

endmodule

bind msg_rx_queue rxq_check chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_mode (lock_mode),
    .wr_en     (wr_en),
    .rel_req   (rel_req),
    .ovr_clr   (ovr_clr),
    .pend_cnt  (pend_cnt),
    .full_flag (full_flag),
    .ovr_flag  (ovr_flag),
    .mb_id     (mb_id),
    .mb_len    (mb_len)
);

// File: tb/msg_rx_queue_tb_top.sv
`timescale 1ns/1ps
module msg_rx_queue_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lock_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_id = '0, wr_len = '0, wr_dlo = '0, wr_dhi = '0;
    logic        rel_req = 1'b0;
    logic        ovr_clr = 1'b0;
    logic [1:0]  pend_cnt;
    logic        full_flag, ovr_flag;
    logic [31:0] mb_id, mb_len, mb_dlo, mb_dhi;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    msg_rx_queue dut_i (
        .clk(clk), .rst_n(rst_n), .lock_mode(lock_mode), .wr_en(wr_en),
        .wr_id(wr_id), .wr_len(wr_len), .wr_dlo(wr_dlo), .wr_dhi(wr_dhi),
        .rel_req(rel_req), .ovr_clr(ovr_clr), .pend_cnt(pend_cnt),
        .full_flag(full_flag), .ovr_flag(ovr_flag), .mb_id(mb_id),
        .mb_len(mb_len), .mb_dlo(mb_dlo), .mb_dhi(mb_dhi)
    );

    // Message words derived from an 8-bit tag; length bits 15:8 carry the tag as filter index.
    function automatic logic [31:0] id_of(logic [7:0] t);  return {t, ~t, 8'h3C, t};          endfunction
    function automatic logic [31:0] len_of(logic [7:0] t); return {t ^ 8'h5A, 8'h77, t, 8'h08}; endfunction
    function automatic logic [31:0] dlo_of(logic [7:0] t); return {4{t}};                      endfunction
    function automatic logic [31:0] dhi_of(logic [7:0] t); return {t, 8'h00, ~t, 8'hFF};       endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    // Row: wr rel lock clr | tag | exp cnt, full, ovr | exp head tag
    localparam int NV = 20;
    localparam logic [23:0] VEC [NV] = '{
        {1'b1,1'b0,1'b0,1'b0, 8'hA1, 2'd1,1'b0,1'b0, 8'hA1}, // R2
        {1'b1,1'b0,1'b0,1'b0, 8'hA2, 2'd2,1'b0,1'b0, 8'hA1}, // R2
        {1'b1,1'b0,1'b0,1'b0, 8'hA3, 2'd3,1'b1,1'b0, 8'hA1}, // R5
        {1'b1,1'b0,1'b0,1'b0, 8'hA4, 2'd3,1'b1,1'b1, 8'hA1}, // R6 R7
        {1'b0,1'b1,1'b0,1'b0, 8'h00, 2'd2,1'b0,1'b1, 8'hA2}, // R3 R5
        {1'b0,1'b1,1'b0,1'b0, 8'h00, 2'd1,1'b0,1'b1, 8'hA4}, // R7
        {1'b0,1'b0,1'b0,1'b1, 8'h00, 2'd1,1'b0,1'b0, 8'hA4}, // R9
        {1'b1,1'b1,1'b0,1'b0, 8'hB1, 2'd1,1'b0,1'b0, 8'hB1}, // R4
        {1'b0,1'b1,1'b0,1'b0, 8'h00, 2'd0,1'b0,1'b0, 8'h00}, // R3
        {1'b0,1'b1,1'b0,1'b0, 8'h00, 2'd0,1'b0,1'b0, 8'h00}, // R10
        {1'b1,1'b0,1'b0,1'b0, 8'hB2, 2'd1,1'b0,1'b0, 8'hB2}, // R10
        {1'b1,1'b0,1'b0,1'b0, 8'hB3, 2'd2,1'b0,1'b0, 8'hB2},
        {1'b1,1'b0,1'b1,1'b0, 8'hB4, 2'd3,1'b1,1'b0, 8'hB2},
        {1'b1,1'b0,1'b1,1'b0, 8'hB5, 2'd3,1'b1,1'b1, 8'hB2}, // R8
        {1'b1,1'b1,1'b1,1'b0, 8'hB6, 2'd3,1'b1,1'b1, 8'hB3}, // R4 at full
        {1'b1,1'b0,1'b1,1'b1, 8'hB7, 2'd3,1'b1,1'b1, 8'hB3}, // R9 set wins
        {1'b0,1'b0,1'b1,1'b1, 8'h00, 2'd3,1'b1,1'b0, 8'hB3}, // R9
        {1'b0,1'b1,1'b1,1'b0, 8'h00, 2'd2,1'b0,1'b0, 8'hB4}, // R8
        {1'b0,1'b1,1'b1,1'b0, 8'h00, 2'd1,1'b0,1'b0, 8'hB6}, // R8
        {1'b0,1'b1,1'b1,1'b0, 8'h00, 2'd0,1'b0,1'b0, 8'h00}
    };

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 count", 32'(pend_cnt), 32'd0);
        chk("R1 full",  32'(full_flag), 32'd0);
        chk("R1 ovr",   32'(ovr_flag), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [7:0] tg, hd;
            tg = VEC[i][19:12];
            hd = VEC[i][7:0];
            wr_en = VEC[i][23]; rel_req = VEC[i][22];
            lock_mode = VEC[i][21]; ovr_clr = VEC[i][20];
            wr_id = id_of(tg); wr_len = len_of(tg);
            wr_dlo = dlo_of(tg); wr_dhi = dhi_of(tg);
            @(negedge clk);
            chk($sformatf("R2/R3/R4 count row %0d", i), 32'(pend_cnt), 32'(VEC[i][11:10]));
            chk($sformatf("R5 full row %0d", i), 32'(full_flag), 32'(VEC[i][9]));
            chk($sformatf("R6/R9 overrun row %0d", i), 32'(ovr_flag), 32'(VEC[i][8]));
            if (VEC[i][11:10] != 2'd0) begin
                chk($sformatf("R7/R8 head id row %0d", i), mb_id, id_of(hd));
                chk($sformatf("R11 filter index row %0d", i), 32'(mb_len[15:8]), 32'(hd));
                chk($sformatf("R11 len row %0d", i), mb_len, len_of(hd));
                chk($sformatf("R2 data row %0d", i), {mb_dlo ^ dlo_of(hd)} | {mb_dhi ^ dhi_of(hd)}, 32'd0);
            end
        end
        wr_en = 1'b0; rel_req = 1'b0; ovr_clr = 1'b0; lock_mode = 1'b0;

        // Directed: reset while partly filled and overrun pending.
        for (int k = 0; k < 4; k++) begin
            wr_en = 1'b1; wr_id = id_of(8'hC0 + 8'(k)); wr_len = len_of(8'hC0 + 8'(k));
            @(negedge clk);
        end
        wr_en = 1'b0;
        chk("R6 overrun before reset", 32'(ovr_flag), 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 count after reset", 32'(pend_cnt), 32'd0);
        chk("R1 full after reset",  32'(full_flag), 32'd0);
        chk("R1 ovr after reset",   32'(ovr_flag), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed: empty release followed by a receive in the next cycle.
        rel_req = 1'b1;
        @(negedge clk);
        rel_req = 1'b0; wr_en = 1'b1;
        wr_id = id_of(8'hD5); wr_len = len_of(8'hD5); wr_dlo = dlo_of(8'hD5); wr_dhi = dhi_of(8'hD5);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R10 count", 32'(pend_cnt), 32'd1);
        chk("R10 id", mb_id, id_of(8'hD5));
        chk("R11 index", 32'(mb_len[15:8]), 32'h0000_00D5);

        finish_run();
    end

endmodule